// File: doc/BRIEF.md
# Three-Level Nested Interrupt Arbiter

This block sits between a set of vectored interrupt request lines and a processor core. Each vector has an enable bit and a one-bit level select. Two vectors can be raised to the topmost level. The rest can be raised only to the middle level. A vector that is not raised sits at the lowest level. Every cycle the block picks one winning request and shows it to the core, together with that request's vector address and level. It does this only when the winner's level is strictly above the level now being serviced.

When the core acknowledges the request, the block does two things in the same edge. It stores the winning vector address and it marks that level as in service. This raises the current level, so later requests at that level or below are held back until the core signals a return from interrupt. A return clears the highest level still marked. Service can therefore nest up to three deep, one handler per level.

Requests are level-sensitive. A source must hold its line until it has been acknowledged. Any merging of several sources onto one vector line is done upstream.

Top module: `irq_nest_arbiter`

## Requirements
- R1: After reset `curLevel` is 0 (no level in service), `ackVec` is 0 and `irqReq` is low while no request line is active.
- R2: Level encoding is 0 = none, 1 = low, 2 = middle, 3 = top. A vector whose `lvlHigh` bit is 0 is at level 1. With the bit set, vectors with index 0 and 1 are at level 3 and vectors with index 2 to 9 are at level 2.
- R3: Among active, enabled requests, the one with the highest level wins, and `irqLvl` shows that level.
- R4: Among active requests at the winning level, the lowest index wins. `irqVec` is 0x03 + 8 × index, so index 0 gives 0x03 and index 9 gives 0x4B.
- R5: A vector whose `enMask` bit is 0 has no effect on `irqReq`, `irqVec` or `irqLvl`.
- R6: `irqReq` is high exactly when the winning request's level is strictly greater than `curLevel`.
- R7: An `irqAck` while `irqReq` is high stores `irqVec` into `ackVec` and sets `curLevel` to the winner's level on the next cycle.
- R8: An `irqAck` while `irqReq` is low changes neither `curLevel` nor `ackVec`.
- R9: `retStrobe` clears the highest in-service level. `curLevel` then falls to the next level still in service, or to 0. A return with nothing in service has no effect.
- R10: When `irqAck` (with `irqReq` high) and `retStrobe` come in the same cycle, the highest old level is cleared and the new level is set. The new level is the one `curLevel` shows afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 10 | Level-sensitive request line per vector |
| enMask | input | 10 | Per-vector enable, 1 = enabled |
| lvlHigh | input | 10 | Per-vector level raise, 1 = raised |
| irqAck | input | 1 | Core accepts the presented request |
| retStrobe | input | 1 | Core returns from the current handler |
| irqReq | output | 1 | A request is presented to the core |
| irqVec | output | 8 | Vector address of the presented request |
| irqLvl | output | 2 | Level of the presented request |
| curLevel | output | 2 | Highest level currently in service |
| ackVec | output | 8 | Vector address stored at the last acknowledge |

## Verification
The hardest state to reach from the ports is a full three-deep nest. Reaching it needs a low request acknowledged, then a middle one, then a top one, with lower requests still asserted and being blocked. After that come returns that unwind one level at a time, and one more return on an empty stack. The directed stimulus builds this nest step by step. It then repeats the sequence with an acknowledge and a return in the same cycle. A long pseudo-random phase follows, mixing requests, masks, level selects, acknowledges and returns, with the behavioural model tracking the nest as a queue.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_MID  = 2'd2,
    LVL_TOP  = 2'd3
  } prio_lvl_e;

  localparam int NUM_LVL = 3;

  typedef struct packed {
    logic takeVec;
    logic popLvl;
  } ctrl_strobe_t;

endpackage

// File: rtl/irq_prio_datapath.sv
module irq_prio_datapath
  import irq_prio_pkg::*;
#(
  parameter int NUM_VEC  = 10,
  parameter int NUM_TOP  = 2,
  parameter int ADDR_W   = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] reqIn,
  input  logic [NUM_VEC-1:0] enMask,
  input  logic [NUM_VEC-1:0] lvlHigh,
  input  ctrl_strobe_t       strobe,
  output logic               winValid,
  output prio_lvl_e          winLvl,
  output logic [ADDR_W-1:0]  winAddr,
  output logic [ADDR_W-1:0]  ackAddr
);

  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [NUM_VEC-1:0] active;
  logic [NUM_VEC-1:0] candTop;
  logic [NUM_VEC-1:0] candMid;
  logic [NUM_VEC-1:0] candLow;
  logic [NUM_VEC-1:0] pick;
  logic [IDX_W-1:0]   winIdx;

  assign active = reqIn & enMask;

  // Level classification per vector: the first NUM_TOP may rise to the top level,
  // the others only to the middle level.
  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_cls
    if (gi < NUM_TOP) begin : g_topable
      assign candTop[gi] = active[gi] & lvlHigh[gi];
      assign candMid[gi] = 1'b0;
    end else begin : g_midable
      assign candTop[gi] = 1'b0;
      assign candMid[gi] = active[gi] & lvlHigh[gi];
    end
    assign candLow[gi] = active[gi] & ~lvlHigh[gi];
  end

  always_comb begin
    if (|candTop) begin
      pick   = candTop;
      winLvl = LVL_TOP;
    end else if (|candMid) begin
      pick   = candMid;
      winLvl = LVL_MID;
    end else if (|candLow) begin
      pick   = candLow;
      winLvl = LVL_LOW;
    end else begin
      pick   = '0;
      winLvl = LVL_NONE;
    end
  end

  assign winValid = |pick;

  // Lowest index wins: scan downward so the last hit is the smallest index.
  always_comb begin
    winIdx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (pick[i]) winIdx = IDX_W'(i);
    end
  end

  assign winAddr = ADDR_W'(VEC_BASE) + ADDR_W'(winIdx) * ADDR_W'(VEC_STEP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackAddr <= '0;
    end else if (strobe.takeVec) begin
      ackAddr <= winAddr;
    end
  end

endmodule

// File: rtl/irq_prio_nest.sv
module irq_prio_nest
  import irq_prio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         winValid,
  input  prio_lvl_e    winLvl,
  input  logic         irqAck,
  input  logic         retStrobe,
  output logic         irqReq,
  output prio_lvl_e    curLevel,
  output ctrl_strobe_t strobe
);

  // bit k marks level k+1 as in service
  logic [NUM_LVL-1:0] inSvc;
  logic [NUM_LVL-1:0] topBit;
  logic [NUM_LVL-1:0] newBit;
  logic [NUM_LVL-1:0] inSvcNext;

  always_comb begin
    topBit   = '0;
    curLevel = LVL_NONE;
    for (int k = 0; k < NUM_LVL; k++) begin
      if (inSvc[k]) begin
        topBit   = '0;
        topBit[k] = 1'b1;
        curLevel = prio_lvl_e'(k + 1);
      end
    end
  end

  assign irqReq = winValid && (winLvl > curLevel);

  assign strobe.takeVec = irqAck && irqReq;
  assign strobe.popLvl  = retStrobe && (|inSvc);

  always_comb begin
    newBit = '0;
    if (winLvl != LVL_NONE) newBit[winLvl - 2'd1] = 1'b1;
  end

  always_comb begin
    inSvcNext = inSvc;
    if (strobe.popLvl)  inSvcNext = inSvcNext & ~topBit;
    if (strobe.takeVec) inSvcNext = inSvcNext | newBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSvc <= '0;
    end else begin
      inSvc <= inSvcNext;
    end
  end

endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
  import irq_prio_pkg::*;
#(
  parameter int NUM_VEC  = 10,
  parameter int NUM_TOP  = 2,
  parameter int ADDR_W   = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] reqIn,
  input  logic [NUM_VEC-1:0] enMask,
  input  logic [NUM_VEC-1:0] lvlHigh,
  input  logic               irqAck,
  input  logic               retStrobe,
  output logic               irqReq,
  output logic [ADDR_W-1:0]  irqVec,
  output logic [1:0]         irqLvl,
  output logic [1:0]         curLevel,
  output logic [ADDR_W-1:0]  ackVec
);

  ctrl_strobe_t strobe;
  logic         winValid;
  prio_lvl_e    winLvl;
  prio_lvl_e    nestLvl;

  irq_prio_datapath #(
    .NUM_VEC (NUM_VEC),
    .NUM_TOP (NUM_TOP),
    .ADDR_W  (ADDR_W),
    .VEC_BASE(VEC_BASE),
    .VEC_STEP(VEC_STEP)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .reqIn   (reqIn),
    .enMask  (enMask),
    .lvlHigh (lvlHigh),
    .strobe  (strobe),
    .winValid(winValid),
    .winLvl  (winLvl),
    .winAddr (irqVec),
    .ackAddr (ackVec)
  );

  irq_prio_nest u_nest (
    .clk      (clk),
    .rstN     (rstN),
    .winValid (winValid),
    .winLvl   (winLvl),
    .irqAck   (irqAck),
    .retStrobe(retStrobe),
    .irqReq   (irqReq),
    .curLevel (nestLvl),
    .strobe   (strobe)
  );

  assign irqLvl   = winLvl;
  assign curLevel = nestLvl;

endmodule

// File: rtl/irq_nest_arbiter_chk.sv
module irq_nest_arbiter_chk #(
  parameter int NUM_TOP  = 2,
  parameter int ADDR_W   = 8,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqAck,
  input logic              retStrobe,
  input logic              irqReq,
  input logic [ADDR_W-1:0] irqVec,
  input logic [1:0]        irqLvl,
  input logic [1:0]        curLevel,
  input logic [ADDR_W-1:0] ackVec
);

  // R6
  req_above_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqLvl > curLevel));

  // R4
  vec_on_grid_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (((int'(irqVec) - VEC_BASE) % VEC_STEP) == 0));

  // R2
  top_level_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqLvl == 2'd3) |-> (int'(irqVec) < VEC_BASE + NUM_TOP * VEC_STEP));

  // R7
  ack_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq && !retStrobe) |=> (curLevel == $past(irqLvl)));

  // R7
  ack_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq) |=> (ackVec == $past(irqVec)));

  // R8
  ack_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !irqReq && !retStrobe) |=> ($stable(curLevel) && $stable(ackVec)));

  // R9
  ret_drops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !irqAck && curLevel != 2'd0) |=> (curLevel < $past(curLevel)));

  // R10
  ack_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq && retStrobe) |=> (curLevel == $past(irqLvl)));

endmodule

bind irq_nest_arbiter irq_nest_arbiter_chk #(
  .NUM_TOP (NUM_TOP),
  .ADDR_W  (ADDR_W),
  .VEC_BASE(VEC_BASE),
  .VEC_STEP(VEC_STEP)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irqAck   (irqAck),
  .retStrobe(retStrobe),
  .irqReq   (irqReq),
  .irqVec   (irqVec),
  .irqLvl   (irqLvl),
  .curLevel (curLevel),
  .ackVec   (ackVec)
);

// File: tb/irq_nest_arbiter_bench.sv
`timescale 1ns/1ps
module irq_nest_arbiter_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic [9:0] reqIn, enMask, lvlHigh;
  logic       irqAck, retStrobe;
  logic       irqReq;
  logic [7:0] irqVec;
  logic [1:0] irqLvl, curLevel;
  logic [7:0] ackVec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int stackM[$];
  int ackM = 0;

  always #2.5 clk = ~clk;

  irq_nest_arbiter u_irq_nest_arbiter (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .enMask(enMask), .lvlHigh(lvlHigh),
    .irqAck(irqAck), .retStrobe(retStrobe), .irqReq(irqReq), .irqVec(irqVec),
    .irqLvl(irqLvl), .curLevel(curLevel), .ackVec(ackVec)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int lvlOf(int i, bit hi);
    if (!hi) return 1;
    return (i < 2) ? 3 : 2;
  endfunction

  task automatic cyc(string tag, logic [9:0] req, logic [9:0] en, logic [9:0] hi,
                     bit ack, bit ret);
    int wl = 0;
    int wi = -1;
    int cur;
    bit expReq;
    reqIn = req; enMask = en; lvlHigh = hi; irqAck = ack; retStrobe = ret;
    #1;
    for (int lv = 3; lv >= 1 && wi < 0; lv--) begin
      for (int i = 0; i < 10; i++) begin
        if (req[i] && en[i] && lvlOf(i, hi[i]) == lv && wi < 0) begin
          wi = i; wl = lv;
        end
      end
    end
    cur = (stackM.size() > 0) ? stackM[$] : 0;
    expReq = (wi >= 0) && (wl > cur);
    chk({tag, " R6"}, "irqReq", int'(irqReq), int'(expReq));
    chk({tag, " R9"}, "curLevel", int'(curLevel), cur);
    chk({tag, " R7"}, "ackVec", int'(ackVec), ackM);
    if (expReq) begin
      chk({tag, " R4"}, "irqVec", int'(irqVec), 3 + 8 * wi);
      chk({tag, " R3"}, "irqLvl", int'(irqLvl), wl);
    end
    if (ret && stackM.size() > 0) void'(stackM.pop_back());
    if (ack && expReq) begin
      stackM.push_back(wl);
      ackM = 3 + 8 * wi;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0; reqIn = '0; enMask = '0; lvlHigh = '0; irqAck = 0; retStrobe = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "reset curLevel", int'(curLevel), 0);
    chk("R1", "reset ackVec", int'(ackVec), 0);
    chk("R1", "reset irqReq", int'(irqReq), 0);
    rstN = 1'b1;
    @(negedge clk);

    // single low request, index 5 -> 0x2B
    cyc("R4", 10'h020, 10'h3FF, 10'h000, 0, 0);
    // all low: index 0 wins; top index alone -> 0x4B
    cyc("R4", 10'h3FF, 10'h3FF, 10'h000, 0, 0);
    cyc("R4", 10'h200, 10'h3FF, 10'h000, 0, 0);
    // middle index 7 beats low index 0
    cyc("R3", 10'h081, 10'h3FF, 10'h080, 0, 0);
    // raised index 1 is top, beats raised index 3 (middle)
    cyc("R2", 10'h00A, 10'h3FF, 10'h00A, 0, 0);
    // raised index 4 is only middle, loses to raised index 0 (top)
    cyc("R2", 10'h011, 10'h3FF, 10'h011, 0, 0);
    cyc("R2", 10'h010, 10'h3FF, 10'h010, 0, 0);
    // masked top request ignored, low index 8 wins
    cyc("R5", 10'h101, 10'h100, 10'h001, 0, 0);
    cyc("R5", 10'h001, 10'h000, 10'h001, 0, 0);
    cyc("R5", 10'h000, 10'h3FF, 10'h000, 0, 0);

    // build full nest
    cyc("R7", 10'h020, 10'h3FF, 10'h000, 1, 0);
    cyc("R6", 10'h021, 10'h3FF, 10'h000, 0, 0);
    cyc("R8", 10'h021, 10'h3FF, 10'h000, 1, 0);
    cyc("R7", 10'h041, 10'h3FF, 10'h040, 1, 0);
    cyc("R6", 10'h0C0, 10'h3FF, 10'h0C0, 0, 0);
    cyc("R7", 10'h0C1, 10'h3FF, 10'h0C1, 1, 0);
    cyc("R6", 10'h3FF, 10'h3FF, 10'h3FF, 1, 0);
    cyc("R9", 10'h000, 10'h3FF, 10'h000, 0, 1);
    cyc("R9", 10'h000, 10'h3FF, 10'h000, 0, 1);
    cyc("R9", 10'h000, 10'h3FF, 10'h000, 0, 1);
    cyc("R9", 10'h000, 10'h3FF, 10'h000, 0, 1);
    cyc("R9", 10'h000, 10'h3FF, 10'h000, 0, 0);

    // ack and return together
    cyc("R10", 10'h004, 10'h3FF, 10'h000, 1, 0);
    cyc("R10", 10'h004, 10'h3FF, 10'h004, 1, 1);
    cyc("R10", 10'h002, 10'h3FF, 10'h002, 1, 1);
    cyc("R10", 10'h000, 10'h3FF, 10'h000, 0, 0);
    cyc("R10", 10'h000, 10'h3FF, 10'h000, 0, 1);
    cyc("R8", 10'h000, 10'h3FF, 10'h000, 1, 0);

    for (int n = 0; n < 2000; n++) begin
      cyc("R3", 10'($urandom), 10'($urandom) | 10'($urandom), 10'($urandom),
          ($urandom % 3) == 0, ($urandom % 4) == 0);
    end
    cyc("R9", 10'h000, 10'h000, 10'h000, 0, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule